// File: doc/BRIEF.md
# Multi-mode programmable down-counter channel

This block is a single down-counting channel for a timer subsystem. A host-side decoder sends it two kinds of one-cycle pulses. A programming pulse carries a 3-bit mode code and a BCD flag. A load pulse carries a new reload value. The channel also watches a gate level. It decrements its count only on cycles where a count-enable strobe is high. From its count, its mode and the gate it forms a single output bit. That bit can be a level raised at terminal count, a retriggerable one-shot, a periodic one-tick pulse train, a square wave or a one-tick strobe.

The count is four decimal digits wide by default and can decrement either as a plain binary number or as packed BCD. A reload value of zero stands for the largest possible count. The gate is sampled on count-enable cycles only, and a rising edge is a high sample that follows a low sample. Byte access, command decoding and interrupt generation are the job of the surrounding logic.

Top module: `pdc_channel`

## Requirements
- R1: After reset `out_o` is 1 and `count_o` is 0.
- R2: With the BCD flag at 0 the count steps down in binary and 0 wraps to 16'hFFFF. With the flag at 1 each nibble is a decimal digit (16'h0100 steps to 16'h0099) and 0 wraps to 16'h9999.
- R3: A reload value of 0 runs for the full range: 65536 decrements in binary, 10000 in BCD, before the count reaches 0 again.
- R4: Mode 0 (terminal-count level): a load drives `out_o` to 0 in the cycle after the load pulse. On the next count-enable cycle the reload value enters the count. `out_o` becomes 1 on the decrement that reaches 0, and both stay put until the next load.
- R5: In mode 0, a load made while counting restarts the count from the new value on the next count-enable cycle, and `out_o` stays 0.
- R6: Mode 1 (one-shot): a load alone leaves `out_o` unchanged. A gate rising edge copies the reload value into the count and drives `out_o` to 0. `out_o` returns to 1 when the count reaches 0. A further rising edge restarts the count.
- R7: Mode 2 (rate): a load made while idle drives `out_o` low for one count-enable cycle, with the count set to N. After that `out_o` goes low for one cycle every N cycles, as the count passes 1. A load made while running is used only at the next reload.
- R8: In mode 2, gate low forces `out_o` to 1 and holds the count. A gate rising edge reloads the count with no low pulse.
- R9: Mode 3 (square wave, N of 2 or more): `out_o` is low for floor(N/2) cycles, then high for ceil(N/2) cycles, and this repeats. The count steps down by 2.
- R10: In mode 3, gate low forces `out_o` to 1 on the next count-enable cycle. When the gate returns high, a new low half starts.
- R11: Mode 4 (software strobe): after a load the count starts on the next count-enable cycle. `out_o` is low for exactly one count-enable cycle when the count reaches 0. A reload restarts the count with no pulse. Gate low freezes the count.
- R12: Mode 5 (hardware strobe): a gate rising edge copies the reload value into the count with `out_o` held at 1. `out_o` is low for exactly one count-enable cycle when the count reaches 0. A rising edge during counting restarts the count.
- R13: On cycles without count-enable, programming or load, `count_o` and `out_o` do not change.
- R14: A programming pulse sets `out_o` to 0 for mode 0 and to 1 for every other mode. Codes 6 and 7 act as modes 2 and 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en_i | input | 1 | Count-enable strobe; gate sampling and decrements happen only while high |
| gate_i | input | 1 | Gate level |
| prog_i | input | 1 | Programming pulse |
| prog_mode_i | input | 3 | Mode code carried with `prog_i` |
| prog_bcd_i | input | 1 | BCD flag carried with `prog_i` |
| load_i | input | 1 | Load pulse |
| load_val_i | input | CNT_W | Reload value carried with `load_i` |
| count_o | output | CNT_W | Live count |
| out_o | output | 1 | Channel output |

## Verification
The bench builds the channel with its default of four digits, which gives a 16-bit count. This lets it test the binary wrap to 16'hFFFF and the BCD wrap to 16'h9999 directly. At this width a full 10000-step BCD run from a zero reload also fits within the run. Mode 3 is tested with both an even and an odd reload, so the unequal halves and the extra high cycle are seen at the output.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        MD_TC_LEVEL  = 3'd0,
        MD_ONESHOT   = 3'd1,
        MD_RATE      = 3'd2,
        MD_SQUARE    = 3'd3,
        MD_SW_STROBE = 3'd4,
        MD_HW_STROBE = 3'd5
    } pdc_mode_e;

    // Codes 6 and 7 fold onto the rate and square-wave behaviours.
    function automatic pdc_mode_e pdc_norm_mode(input logic [MODE_W-1:0] code);
        case (code)
            3'd6:    return MD_RATE;
            3'd7:    return MD_SQUARE;
            default: return pdc_mode_e'(code);
        endcase
    endfunction

endpackage

// File: rtl/pdc_bcd_digit.sv
// One decimal digit minus 0, 1 or 2, modulo ten.
module pdc_bcd_digit (
    input  logic [3:0] d_i,
    input  logic [1:0] sub_i,
    output logic [3:0] q_o
);
    always_comb begin
        if (d_i >= {2'b00, sub_i}) begin
            q_o = d_i - {2'b00, sub_i};
        end else begin
            q_o = d_i + 4'd10 - {2'b00, sub_i};
        end
    end
endmodule

// File: rtl/pdc_dec.sv
// Decrement by one or two, in binary or packed BCD (DIGITS >= 2).
module pdc_dec #(
    parameter int DIGITS = 4,
    localparam int CNT_W = 4 * DIGITS
) (
    input  logic [CNT_W-1:0] val_i,
    input  logic             bcd_i,
    input  logic             two_i,
    output logic [CNT_W-1:0] val_o
);
    logic [CNT_W-1:0]  bin_q;
    logic [CNT_W-1:0]  bcd_q;
    logic [DIGITS-2:0] brw;

    assign bin_q = val_i - (two_i ? CNT_W'(2) : CNT_W'(1));

    for (genvar i = 0; i < DIGITS; i++) begin : g_dig
        logic [1:0] sub;
        if (i == 0) begin : g_lsd
            assign sub = {two_i, ~two_i};
        end else begin : g_upper
            assign sub = {1'b0, brw[i-1]};
        end
        if (i < DIGITS - 1) begin : g_brw
            assign brw[i] = (val_i[4*i +: 4] < {2'b00, sub});
        end
        pdc_bcd_digit u_digit (
            .d_i   (val_i[4*i +: 4]),
            .sub_i (sub),
            .q_o   (bcd_q[4*i +: 4])
        );
    end

    assign val_o = bcd_i ? bcd_q : bin_q;
endmodule

// File: rtl/pdc_gate_edge.sv
// Samples the gate on count-enable cycles and flags a low-to-high change.
module pdc_gate_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic gate_i,
    output logic rise_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = tick_i ? gate_i : prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= prev_d;
        end
    end

    assign rise_o = tick_i & gate_i & ~prev_q;
endmodule

// File: rtl/pdc_channel.sv
module pdc_channel
    import pdc_pkg::*;
#(
    parameter int DIGITS = 4,
    localparam int CNT_W = 4 * DIGITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en_i,
    input  logic             gate_i,
    input  logic             prog_i,
    input  logic [2:0]       prog_mode_i,
    input  logic             prog_bcd_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] count_o,
    output logic             out_o
);
    typedef struct packed {
        pdc_mode_e        mode;
        logic             bcd;
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] reload;   // most recently loaded value
        logic [CNT_W-1:0] active;   // value governing the current square-wave cycle
        logic             out;
        logic             run;
        logic             pend;     // a load waits for the next count-enable cycle
        logic             have;     // a value has been loaded since programming
        logic             hi_half;  // square wave is in its high half
    } pdc_state_t;

    pdc_state_t       st_d, st_q;
    logic             rise;
    logic [CNT_W-1:0] dec_val;
    logic [CNT_W-1:0] half_rel;
    logic [CNT_W-1:0] half_act;
    logic             at_one;
    logic             at_two;
    logic             hi_done;
    logic [2:0]       mode_q;

    pdc_gate_edge u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (cnt_en_i),
        .gate_i (gate_i),
        .rise_o (rise)
    );

    pdc_dec #(.DIGITS(DIGITS)) u_dec (
        .val_i (st_q.count),
        .bcd_i (st_q.bcd),
        .two_i (st_q.mode == MD_SQUARE),
        .val_o (dec_val)
    );

    assign half_rel = {st_q.reload[CNT_W-1:1], 1'b0};
    assign half_act = {st_q.active[CNT_W-1:1], 1'b0};
    assign at_one   = (st_q.count == CNT_W'(1));
    assign at_two   = (st_q.count == CNT_W'(2));
    // Odd values stretch the high half by one extra step to zero.
    assign hi_done  = st_q.active[0] ? (st_q.count == '0) : at_two;

    always_comb begin
        st_d = st_q;

        if (cnt_en_i) begin
            case (st_q.mode)
                MD_TC_LEVEL: begin
                    if (st_q.pend) begin
                        st_d.count = st_q.reload;
                        st_d.run   = 1'b1;
                        st_d.pend  = 1'b0;
                    end else if (st_q.run && gate_i) begin
                        st_d.count = dec_val;
                        if (at_one) begin
                            st_d.out = 1'b1;
                            st_d.run = 1'b0;
                        end
                    end
                end

                MD_SW_STROBE: begin
                    st_d.out = 1'b1;
                    if (st_q.pend) begin
                        st_d.count = st_q.reload;
                        st_d.run   = 1'b1;
                        st_d.pend  = 1'b0;
                    end else if (st_q.run && gate_i) begin
                        st_d.count = dec_val;
                        if (at_one) begin
                            st_d.out = 1'b0;
                            st_d.run = 1'b0;
                        end
                    end
                end

                MD_ONESHOT: begin
                    if (rise && st_q.have) begin
                        st_d.count = st_q.reload;
                        st_d.out   = 1'b0;
                        st_d.run   = 1'b1;
                    end else if (st_q.run) begin
                        st_d.count = dec_val;
                        if (at_one) begin
                            st_d.out = 1'b1;
                            st_d.run = 1'b0;
                        end
                    end
                end

                MD_HW_STROBE: begin
                    st_d.out = 1'b1;
                    if (rise && st_q.have) begin
                        st_d.count = st_q.reload;
                        st_d.run   = 1'b1;
                    end else if (st_q.run) begin
                        st_d.count = dec_val;
                        if (at_one) begin
                            st_d.out = 1'b0;
                            st_d.run = 1'b0;
                        end
                    end
                end

                MD_RATE: begin
                    st_d.out = 1'b1;
                    if (!gate_i) begin
                        st_d.count = st_q.count;
                    end else if (st_q.pend) begin
                        st_d.count = st_q.reload;
                        st_d.out   = 1'b0;
                        st_d.run   = 1'b1;
                        st_d.pend  = 1'b0;
                    end else if (rise && st_q.have) begin
                        st_d.count = st_q.reload;
                        st_d.run   = 1'b1;
                    end else if (st_q.run) begin
                        if (at_one) begin
                            st_d.count = st_q.reload;
                            st_d.out   = 1'b0;
                        end else begin
                            st_d.count = dec_val;
                        end
                    end
                end

                MD_SQUARE: begin
                    if (!gate_i) begin
                        st_d.out     = 1'b1;
                        st_d.run     = 1'b0;
                        st_d.hi_half = 1'b0;
                        st_d.pend    = st_q.have;
                        if (st_q.have) begin
                            st_d.count = half_rel;
                        end
                    end else if (st_q.pend) begin
                        st_d.count   = half_rel;
                        st_d.active  = st_q.reload;
                        st_d.out     = 1'b0;
                        st_d.hi_half = 1'b0;
                        st_d.run     = 1'b1;
                        st_d.pend    = 1'b0;
                    end else if (st_q.run) begin
                        if (!st_q.hi_half) begin
                            if (at_two) begin
                                st_d.count   = half_act;
                                st_d.out     = 1'b1;
                                st_d.hi_half = 1'b1;
                            end else begin
                                st_d.count = dec_val;
                            end
                        end else begin
                            if (hi_done) begin
                                st_d.count   = half_rel;
                                st_d.active  = st_q.reload;
                                st_d.out     = 1'b0;
                                st_d.hi_half = 1'b0;
                            end else begin
                                st_d.count = dec_val;
                            end
                        end
                    end
                end

                default: begin
                    st_d.count = st_q.count;
                end
            endcase
        end

        if (load_i) begin
            st_d.reload = load_val_i;
            st_d.have   = 1'b1;
            case (st_q.mode)
                MD_TC_LEVEL: begin
                    st_d.out  = 1'b0;
                    st_d.run  = 1'b0;
                    st_d.pend = 1'b1;
                end
                MD_SW_STROBE: begin
                    st_d.run  = 1'b0;
                    st_d.pend = 1'b1;
                end
                MD_RATE, MD_SQUARE: begin
                    if (!st_q.run) begin
                        st_d.pend = 1'b1;
                    end
                end
                default: begin
                    st_d.have = 1'b1;
                end
            endcase
        end

        if (prog_i) begin
            st_d.mode    = pdc_norm_mode(prog_mode_i);
            st_d.bcd     = prog_bcd_i;
            st_d.out     = (pdc_norm_mode(prog_mode_i) != MD_TC_LEVEL);
            st_d.run     = 1'b0;
            st_d.pend    = 1'b0;
            st_d.have    = 1'b0;
            st_d.hi_half = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode    <= MD_HW_STROBE;
            st_q.bcd     <= 1'b0;
            st_q.count   <= '0;
            st_q.reload  <= '0;
            st_q.active  <= '0;
            st_q.out     <= 1'b1;
            st_q.run     <= 1'b0;
            st_q.pend    <= 1'b0;
            st_q.have    <= 1'b0;
            st_q.hi_half <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_q  = st_q.mode;
    assign count_o = st_q.count;
    assign out_o   = st_q.out;
endmodule

// File: rtl/pdc_channel_chk.sv
module pdc_channel_chk
    import pdc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_en_i,
    input logic             gate_i,
    input logic             prog_i,
    input logic [2:0]       prog_mode_i,
    input logic             load_i,
    input logic [CNT_W-1:0] count_o,
    input logic             out_o,
    input logic [2:0]       mode_q
);
    p_quiet_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en_i && !prog_i && !load_i) |=> ($stable(count_o) && $stable(out_o)));

    p_prog_level_r14: assert property (@(posedge clk) disable iff (!rst_n)
        prog_i |=> (out_o == ($past(prog_mode_i) != 3'd0)));

    p_load_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MD_TC_LEVEL && load_i && !prog_i) |=> !out_o);

    p_rate_gate_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MD_RATE && !gate_i && cnt_en_i && !prog_i) |=> out_o);

    p_square_gate_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MD_SQUARE && !gate_i && cnt_en_i && !prog_i) |=> out_o);

    p_sw_strobe_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MD_SW_STROBE && !out_o && cnt_en_i && !prog_i) |=> out_o);

    p_hw_strobe_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MD_HW_STROBE && !out_o && cnt_en_i && !prog_i) |=> out_o);
endmodule

bind pdc_channel pdc_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt_en_i    (cnt_en_i),
    .gate_i      (gate_i),
    .prog_i      (prog_i),
    .prog_mode_i (prog_mode_i),
    .load_i      (load_i),
    .count_o     (count_o),
    .out_o       (out_o),
    .mode_q      (mode_q)
);

// File: tb/tb_pdc_channel.sv
module tb_pdc_channel;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 1'b1;
    logic        gate = 1'b1;
    logic        prog = 1'b0;
    logic [2:0]  prog_mode = 3'd0;
    logic        prog_bcd = 1'b0;
    logic        load = 1'b0;
    logic [15:0] load_val = 16'd0;
    logic [15:0] count;
    logic        out;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pdc_channel dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cnt_en_i    (cnt_en),
        .gate_i      (gate),
        .prog_i      (prog),
        .prog_mode_i (prog_mode),
        .prog_bcd_i  (prog_bcd),
        .load_i      (load),
        .load_val_i  (load_val),
        .count_o     (count),
        .out_o       (out)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h) at %0t",
                     req, act, act, exp, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_prog(input logic [2:0] m, input logic b);
        prog = 1'b1; prog_mode = m; prog_bcd = b;
        step(1);
        prog = 1'b0;
    endtask

    task automatic do_load(input logic [15:0] v);
        load = 1'b1; load_val = v;
        step(1);
        load = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 out after reset", int'(out), 1);
        chk("R1 count after reset", int'(count), 0);
    endtask

    task automatic t_mode0;
        gate = 1'b1; step(2);
        do_prog(3'd0, 1'b0);
        chk("R14 mode0 program level", int'(out), 0);
        do_load(16'd4);
        chk("R4 low after load", int'(out), 0);
        step(4);
        chk("R4 count one before end", int'(count), 1);
        chk("R4 still low", int'(out), 0);
        step(1);
        chk("R4 high at zero", int'(out), 1);
        step(3);
        chk("R4 stays high", int'(out), 1);
        chk("R4 count held at zero", int'(count), 0);
        do_load(16'd6);
        step(3);
        chk("R5 count before reload", int'(count), 4);
        do_load(16'd5);
        step(1);
        chk("R5 restarted count", int'(count), 5);
        chk("R5 still low", int'(out), 0);
        step(5);
        chk("R5 high after new count", int'(out), 1);
    endtask

    task automatic t_mode1;
        gate = 1'b0; step(2);
        do_prog(3'd1, 1'b0);
        chk("R14 mode1 program level", int'(out), 1);
        do_load(16'd3);
        step(2);
        chk("R6 load alone keeps out high", int'(out), 1);
        gate = 1'b1; step(1);
        chk("R6 trigger low", int'(out), 0);
        chk("R6 trigger count", int'(count), 3);
        gate = 1'b0; step(1);
        chk("R6 counting with gate low", int'(count), 2);
        gate = 1'b1; step(1);
        chk("R6 retrigger count", int'(count), 3);
        step(2);
        chk("R6 low before end", int'(out), 0);
        step(1);
        chk("R6 high at zero", int'(out), 1);
        do_load(16'd2);
        step(2);
        chk("R6 new load no effect on out", int'(out), 1);
        chk("R6 new load no effect on count", int'(count), 0);
        gate = 1'b0; step(1);
        gate = 1'b1; step(1);
        chk("R6 new value on next edge", int'(count), 2);
        chk("R6 low on next edge", int'(out), 0);
    endtask

    task automatic t_mode2;
        gate = 1'b1; step(2);
        do_prog(3'd2, 1'b0);
        do_load(16'd4);
        for (int k = 1; k <= 12; k++) begin
            step(1);
            chk("R7 pulse train N=4", int'(out), (k % 4 == 1) ? 0 : 1);
        end
        do_load(16'd3);
        chk("R7 reload keeps old value", int'(count), 4);
        chk("R7 pulse on old period", int'(out), 0);
        step(3);
        chk("R7 high between pulses", int'(out), 1);
        step(1);
        chk("R7 new period takes over", int'(count), 3);
        chk("R7 pulse with new value", int'(out), 0);
        step(3);
        chk("R7 period of three", int'(out), 0);
        gate = 1'b0; step(1);
        chk("R8 gate low forces high", int'(out), 1);
        step(2);
        chk("R8 gate low still high", int'(out), 1);
        chk("R8 gate low holds count", int'(count), 3);
        gate = 1'b1; step(1);
        chk("R8 rise reload count", int'(count), 3);
        chk("R8 rise no pulse", int'(out), 1);
        step(2);
        chk("R8 counting after rise", int'(count), 1);
        step(1);
        chk("R8 pulse after rise period", int'(out), 0);
    endtask

    task automatic t_mode3;
        gate = 1'b1; step(2);
        do_prog(3'd3, 1'b0);
        do_load(16'd6);
        for (int k = 1; k <= 12; k++) begin
            step(1);
            chk("R9 square even N=6", int'(out), (((k - 1) / 3) % 2 == 0) ? 0 : 1);
        end
        do_prog(3'd3, 1'b0);
        do_load(16'd5);
        for (int k = 1; k <= 10; k++) begin
            int ph;
            ph = (k - 1) % 5;
            step(1);
            chk("R9 square odd N=5", int'(out), (ph < 2) ? 0 : 1);
        end
        gate = 1'b0; step(1);
        chk("R10 gate low forces high", int'(out), 1);
        step(2);
        chk("R10 gate low stays high", int'(out), 1);
        gate = 1'b1; step(1);
        chk("R10 restart low half", int'(out), 0);
        chk("R10 restart count", int'(count), 4);
    endtask

    task automatic t_mode4;
        gate = 1'b1; step(2);
        do_prog(3'd4, 1'b0);
        chk("R14 mode4 program level", int'(out), 1);
        do_load(16'd5);
        for (int k = 1; k <= 7; k++) begin
            step(1);
            chk("R11 strobe N=5", int'(out), (k == 6) ? 0 : 1);
        end
        do_load(16'd8);
        step(3);
        chk("R11 counting", int'(count), 6);
        gate = 1'b0; step(4);
        chk("R11 gate low freezes count", int'(count), 6);
        chk("R11 gate low out high", int'(out), 1);
        gate = 1'b1; step(2);
        chk("R11 resumes", int'(count), 4);
        do_load(16'd9);
        step(1);
        chk("R11 reload restarts", int'(count), 9);
        chk("R11 reload no pulse", int'(out), 1);
        step(9);
        chk("R11 strobe after reload", int'(out), 0);
        chk("R11 count zero at strobe", int'(count), 0);
        step(1);
        chk("R11 strobe one cycle", int'(out), 1);
    endtask

    task automatic t_mode5;
        gate = 1'b0; step(2);
        do_prog(3'd5, 1'b0);
        do_load(16'd3);
        step(2);
        chk("R12 idle until edge", int'(out), 1);
        gate = 1'b1; step(1);
        chk("R12 edge loads count", int'(count), 3);
        chk("R12 edge keeps out high", int'(out), 1);
        step(2);
        chk("R12 counting", int'(count), 1);
        step(1);
        chk("R12 strobe low", int'(out), 0);
        step(1);
        chk("R12 strobe one cycle", int'(out), 1);
        gate = 1'b0; step(1);
        gate = 1'b1; step(1);
        chk("R12 second trigger", int'(count), 3);
        gate = 1'b0; step(1);
        chk("R12 counts with gate low", int'(count), 2);
        gate = 1'b1; step(1);
        chk("R12 retrigger restarts", int'(count), 3);
        chk("R12 retrigger out high", int'(out), 1);
    endtask

    task automatic t_count_enable;
        gate = 1'b1; step(2);
        do_prog(3'd4, 1'b0);
        do_load(16'd6);
        step(1);
        chk("R13 loaded", int'(count), 6);
        cnt_en = 1'b0; step(3);
        chk("R13 no enable holds count", int'(count), 6);
        chk("R13 no enable holds out", int'(out), 1);
        cnt_en = 1'b1; step(1);
        chk("R13 enable decrements", int'(count), 5);
        for (int i = 0; i < 4; i++) begin
            cnt_en = 1'b0; step(1);
            cnt_en = 1'b1; step(1);
        end
        chk("R13 alternate enable", int'(count), 1);
    endtask

    task automatic t_bcd;
        gate = 1'b1; step(2);
        do_prog(3'd4, 1'b0);
        do_load(16'h0000);
        step(2);
        chk("R2 binary wrap", int'(count), 16'hFFFF);
        do_prog(3'd4, 1'b1);
        do_load(16'h0100);
        step(1);
        chk("R2 bcd loaded", int'(count), 16'h0100);
        step(1);
        chk("R2 bcd borrow chain", int'(count), 16'h0099);
        do_load(16'h0000);
        step(2);
        chk("R2 bcd wrap", int'(count), 16'h9999);
        do_load(16'h0000);
        step(10000);
        chk("R3 bcd full range not done", int'(out), 1);
        chk("R3 bcd full range count", int'(count), 1);
        step(1);
        chk("R3 bcd full range strobe", int'(out), 0);
    endtask

    task automatic t_alias;
        gate = 1'b1; step(2);
        do_prog(3'd6, 1'b0);
        chk("R14 code6 program level", int'(out), 1);
        do_load(16'd4);
        step(1);
        chk("R14 code6 as rate pulse", int'(out), 0);
        step(1);
        chk("R14 code6 high", int'(out), 1);
        step(3);
        chk("R14 code6 period", int'(out), 0);
        do_prog(3'd7, 1'b0);
        do_load(16'd6);
        step(3);
        chk("R14 code7 as square low", int'(out), 0);
        step(1);
        chk("R14 code7 as square high", int'(out), 1);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_mode0();
        t_mode1();
        t_mode2();
        t_mode3();
        t_mode4();
        t_mode5();
        t_count_enable();
        t_bcd();
        t_alias();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule